// File: doc/BRIEF.md
# Carry-less Dual Product Accumulator

This unit is the arithmetic core for folding steps in polynomial checksum engines. Each of its two 128-bit operands is treated as a pair of 64-bit doublewords. The unit forms two carry-less (GF(2)) products in a single operation. One product pairs the two upper doublewords and the other pairs the two lower doublewords. The unit XORs the two products together and, when asked to, also XORs in a third 128-bit operand. Each product is 127 bits wide and sits zero-extended at the least significant end of a 128-bit word.

Callers can obtain a single product by setting one lower doubleword to zero. They can merge a value in at no extra cost by setting one lower doubleword to one, so that the other lower doubleword passes straight into the sum. The result is registered once, so it appears one clock after the operands are presented. It then holds until the next operation.

Top module: `clmul_dual_mac`

## Requirements
- R1: When `acc_en` is 0, the result one cycle later equals clmul(a[127:64], b[127:64]) XOR clmul(a[63:0], b[63:0]). Each clmul is a 64x64 carry-less product, placed in bits [126:0] with bit 127 equal to 0.
- R2: When `acc_en` is 1, the R1 value is also XORed with `op_c`. When `acc_en` is 0, `op_c` has no effect on the result.
- R3: If a[63:0] or b[63:0] is zero, the result contains only the upper product and any accumulate term.
- R4: If b[63:0] equals 1, the value a[63:0] appears in result bits [63:0] and is XORed with the upper product.
- R5: `res_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1.
- R6: Result bit 127 is 0 unless accumulation is enabled and `op_c[127]` is 1.
- R7: While `in_valid` is 0, `result` keeps its last value.
- R8: After reset, `res_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are present this cycle |
| acc_en | input | 1 | 1: also XOR in op_c |
| op_a | input | 128 | First operand, upper and lower doublewords |
| op_b | input | 128 | Second operand, upper and lower doublewords |
| op_c | input | 128 | Accumulate operand |
| res_valid | output | 1 | Result updated in this cycle |
| result | output | 128 | XOR of both products and the optional accumulate term |

## Verification
The assertions assume that `in_valid`, `acc_en` and the operands are at known values at every clock edge after reset, because the pass-through and top-bit checks compare against values captured from the inputs. The bench drives every input on the falling edge from explicit values and never leaves one unknown. It holds `in_valid` low between operations so that the hold behaviour can be observed. The random operands come from a seeded generator. The bench mixes them with the corner values 0, 1 and all-ones in the lower and upper doublewords.

// File: rtl/clmul_dual_mac.sv
module clmul_dual_mac #(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            acc_en,
  input  logic [2*DW-1:0] op_a,
  input  logic [2*DW-1:0] op_b,
  input  logic [2*DW-1:0] op_c,
  output logic            res_valid,
  output logic [2*DW-1:0] result
);
  localparam int W = 2 * DW;

  function automatic logic [W-1:0] clmul(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DW; i++)
      for (int j = 0; j < DW; j++)
        acc[i+j] = acc[i+j] ^ (x[i] & y[j]);
    return acc;
  endfunction

  logic [W-1:0] prod_hi, prod_lo, addend, sum;

  assign prod_hi = clmul(op_a[W-1:DW], op_b[W-1:DW]);
  assign prod_lo = clmul(op_a[DW-1:0], op_b[DW-1:0]);
  assign addend  = acc_en ? op_c : '0;
  assign sum     = prod_hi ^ prod_lo ^ addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) result <= sum;
    end
  end

  a_r5_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r6_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(acc_en && op_c[W-1])) |=> !result[W-1]);
  a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_en && op_a[W-1:DW] == '0 && op_b[DW-1:0] == '0) |=> result == '0);
  a_r4_pass_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_en && op_a[W-1:DW] == '0 && op_b[DW-1:0] == DW'(1))
    |=> result == {{DW{1'b0}}, $past(op_a[DW-1:0])});
endmodule

// File: tb/tb_clmul_dual_mac.sv
module tb_clmul_dual_mac;
  logic clk = 0, rst_n = 0, in_valid = 0, acc_en = 0;
  logic [127:0] op_a = '0, op_b = '0, op_c = '0;
  logic res_valid;
  logic [127:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clmul_dual_mac dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_en(acc_en),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .res_valid(res_valid), .result(result));

  function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] sh, acc;
    sh = {64'd0, x};
    acc = '0;
    for (int i = 0; i < 64; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  function automatic logic [127:0] ref_op(input logic [127:0] a, b, c, input logic e);
    return ref_mul(a[127:64], b[127:64]) ^ ref_mul(a[63:0], b[63:0]) ^ (e ? c : 128'd0);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [127:0] a, b, c, input logic e);
    logic [127:0] exp;
    exp = ref_op(a, b, c, e);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; acc_en = e; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    op_a = rnd128(); op_b = rnd128(); op_c = rnd128(); acc_en = 1;
    check({req, " result"}, result, exp);
    check("R5 valid", {127'd0, res_valid}, 128'd1);
    if (!(e && c[127])) check("R6 top bit", {127'd0, result[127]}, 128'd0);
    @(negedge clk);
    check("R5 valid low", {127'd0, res_valid}, 128'd0);
    check("R7 hold", result, exp);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    check("R8 valid", {127'd0, res_valid}, 128'd0);
    check("R8 result", result, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check("R8 idle", result, 128'd0);

    run("R1 zeros", '0, '0, '0, 0);
    run("R1 ones", '1, '1, '0, 0);
    run("R1 unit", {64'd1, 64'd1}, {64'd1, 64'd1}, '0, 0);
    run("R2 acc ones", '1, '1, '1, 1);
    run("R2 ignore c", '1, rnd128(), '1, 0);
    run("R3 low zero", rnd128(), {$urandom, $urandom, 64'd0}, '0, 0);
    run("R3 low zero acc", {$urandom, $urandom, 64'd0}, rnd128(), rnd128(), 1);
    run("R4 pass low", {64'd0, $urandom, $urandom}, {$urandom, $urandom, 64'd1}, '0, 0);
    run("R4 pass xor", rnd128(), {$urandom, $urandom, 64'd1}, '0, 0);
    run("R6 acc top", rnd128(), rnd128(), {1'b1, 127'd0}, 1);
    for (int k = 0; k < 40; k++) begin
      logic e;
      e = $urandom % 2;
      run(e ? "R2 random" : "R1 random", rnd128(), rnd128(), rnd128(), e);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule